// File: doc/BRIEF.md
# Dual-Slope Two-Channel PWM Timer

This block is a 16-bit timer whose counter ramps up from zero to a TOP value, turns round, ramps back down to zero and turns round again. Two compare channels, A and B, watch the counter and each drives its own waveform pin, giving a centre-aligned PWM signal. The duty cycle of each channel follows its compare value, and the period is twice TOP counter ticks. A prescaler divides the system clock to set the tick rate. Software programs the timer through a plain write strobe with a two-bit address. A run enable starts and freezes the count.

TOP comes from one of three places: a fixed 8-, 9- or 10-bit maximum, a dedicated TOP register, or compare register A. When compare A supplies TOP, channel A only sets the period and its pin holds a steady level. Both compare values and the TOP register are double buffered. In phase-correct mode the written values take effect when the counter turns at TOP. In frequency-correct mode they take effect when it turns at zero. While the counter is stopped, written values take effect at once.

The counter sequencer has four named states. HOLD_RISE and HOLD_FALL are frozen states that remember the direction. RISE counts up and FALL counts down. The transitions are:
- resume: a HOLD state goes to its matching running state when the timer is allowed to run. No tick is counted on that edge.
- freeze: a running state goes to its matching HOLD state when running is no longer allowed.
- peak turn: RISE goes to FALL on a tick taken at or above TOP.
- floor turn: FALL goes to RISE on a tick taken at zero.

Top module: `dual_slope_pwm`

## Requirements
- R1: While running, the counter steps once per prescaled tick through 0, 1 … TOP, TOP−1 … 1 and repeats, so one PWM period lasts 2·TOP ticks.
- R2: Output mode 2'b10 is non-inverted. On a rising compare match the pin clears, and on a falling compare match it sets. The pin is high for 2·C ticks per period when 1 ≤ C < TOP.
- R3: Output mode 2'b11 gives the complement of the non-inverted waveform, so the pin is high for 2·TOP − 2·C ticks per period.
- R4: Output modes 2'b00 and 2'b01 disconnect a channel: its output enable is low and its pin is 0. For modes 2'b10 and 2'b11 the output enable is high.
- R5: The TOP source is control bits [2:0]: 0 = 255, 1 = 511, 2 = 1023, 3 = TOP register, 4 = compare register A, 5 to 7 = TOP register.
- R6: When compare A is the TOP source, non-inverted channel A stays high for the whole period, while channel B still produces its own duty cycle.
- R7: A compare match at TOP causes no output change. Compare value 0 keeps a non-inverted pin low. A compare value equal to or above TOP keeps it high.
- R8: Clock select is control bits [6:4]. Codes 1 to 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 freeze the counter and the pins.
- R9: With run_en low the counter and the pins stay frozen whatever the clock select.
- R10: Compare A (address 1), compare B (address 2) and the TOP register (address 3) are buffered. Control bit 3 = 0 (phase-correct) loads them when the counter turns at TOP. Bit 3 = 1 (frequency-correct) loads them when it turns at zero. While stopped they load at once.
- R11: top_flag is high for exactly one clock each time the counter steps onto TOP, once per period.
- R12: Reset clears all registers and the count. After reset both pins, both output enables and top_flag are 0.
- R13: The control register is address 0, with the channel A output mode in bits [8:7] and the channel B output mode in bits [10:9]. It takes effect on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows the counter to run |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 compare A, 2 compare B, 3 TOP |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | Channel A waveform |
| oe_a | output | 1 | Channel A output enable |
| pwm_b | output | 1 | Channel B waveform |
| oe_b | output | 1 | Channel B output enable |
| top_flag | output | 1 | One-clock pulse when the counter reaches TOP |

## Verification
Two functions can fall in the same cycle: a buffered-value load and a compare evaluation on the same counter edge. A match and the turnaround at TOP can also coincide. The bench provokes the first by writing compare B on the very clock the counter sits at TOP. It then counts the high cycles of pwm_b over the next two periods, which must read 10 then 30 in phase-correct mode and 20 then 30 in frequency-correct mode. The second is provoked by setting a compare value equal to TOP and by using compare A as TOP. There the pin must stay high across the entire measured period.

// File: rtl/dslpwm_pkg.sv
package dslpwm_pkg;

    // Register addresses of the write port
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMPA = 2'd1;
    localparam logic [1:0] ADDR_CMPB = 2'd2;
    localparam logic [1:0] ADDR_TOP  = 2'd3;

    // TOP source codes
    localparam logic [2:0] SRC_FIX8   = 3'd0;
    localparam logic [2:0] SRC_FIX9   = 3'd1;
    localparam logic [2:0] SRC_FIX10  = 3'd2;
    localparam logic [2:0] SRC_TOPREG = 3'd3;
    localparam logic [2:0] SRC_CMPA   = 3'd4;

    // Output mode codes
    localparam logic [1:0] OM_PLAIN = 2'b10;
    localparam logic [1:0] OM_INV   = 2'b11;

    localparam int CTRL_W = 11;

    typedef struct packed {
        logic [1:0] om_b;      // [10:9]
        logic [1:0] om_a;      // [8:7]
        logic [2:0] clk_sel;   // [6:4]
        logic       freq_mode; // [3]
        logic [2:0] top_src;   // [2:0]
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_HOLD_RISE = 2'd0,
        ST_HOLD_FALL = 2'd1,
        ST_RISE      = 2'd2,
        ST_FALL      = 2'd3
    } ramp_state_t;

    // log2 of the prescale division for a clock-select code
    function automatic int sel_shift(input logic [2:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return 0;
        endcase
    endfunction

    function automatic logic sel_runs(input logic [2:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

endpackage

// File: rtl/dslpwm_prescale.sv
module dslpwm_prescale
    import dslpwm_pkg::*;
#(
    parameter int PS_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);

    logic [PS_W-1:0] pcnt_q;
    logic [PS_W-1:0] limit;

    always_comb begin
        limit  = PS_W'((1 << sel_shift(sel_i)) - 1);
        tick_o = run_i && (pcnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run_i || tick_o) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && limit != '0) |=> (!tick_o || sel_i != $past(sel_i)))
        else $error("prescaled tick repeated on consecutive clocks");

endmodule

// File: rtl/dslpwm_ramp.sv
module dslpwm_ramp
    import dslpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             freq_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             falling_o,
    output logic             load_o,
    output logic             top_flag_o
);

    ramp_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             turn_top, turn_bot;
    logic             flag_q, flag_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HOLD_RISE;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    // Next state and count
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        turn_top = 1'b0;
        turn_bot = 1'b0;
        unique case (st_q)
            ST_HOLD_RISE: if (run_i) st_d = ST_RISE;
            ST_HOLD_FALL: if (run_i) st_d = ST_FALL;
            ST_RISE: begin
                if (!run_i) begin
                    st_d = ST_HOLD_RISE;
                end else if (tick_i) begin
                    if (top_i == '0) begin
                        cnt_d    = '0;
                        turn_top = 1'b1;
                        turn_bot = 1'b1;
                    end else if (cnt_q >= top_i) begin
                        cnt_d    = cnt_q - 1'b1;
                        st_d     = ST_FALL;
                        turn_top = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FALL: begin
                if (!run_i) begin
                    st_d = ST_HOLD_FALL;
                end else if (tick_i) begin
                    if (top_i == '0) begin
                        cnt_d    = '0;
                        st_d     = ST_RISE;
                        turn_top = 1'b1;
                        turn_bot = 1'b1;
                    end else if (cnt_q == '0) begin
                        cnt_d    = CNT_W'(1);
                        st_d     = ST_RISE;
                        turn_bot = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: st_d = ST_HOLD_RISE;
        endcase
    end

    // Outputs
    always_comb begin
        flag_d     = run_i && tick_i && (st_q == ST_RISE) && (top_i != '0)
                     && (CNT_W'(cnt_q + 1'b1) == top_i);
        load_o     = !run_i || (freq_i ? turn_bot : turn_top);
        falling_o  = (st_q == ST_FALL) || (st_q == ST_HOLD_FALL);
        cnt_o      = cnt_q;
        top_flag_o = flag_q;
    end

    // R1
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RISE || st_q == ST_FALL) |=>
            (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)
             || cnt_q == CNT_W'($past(cnt_q) - 1'b1)))
        else $error("counter moved by more than one step");

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD_RISE || st_q == ST_HOLD_FALL) |=> $stable(cnt_q))
        else $error("counter moved while held");

    // R11
    flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> !flag_q)
        else $error("top flag wider than one clock");

endmodule

// File: rtl/dslpwm_shadow.sv
module dslpwm_shadow
    import dslpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] cmp_a_o,
    output logic [CNT_W-1:0] cmp_b_o,
    output logic [CNT_W-1:0] top_o
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] buf_a_q, buf_b_q, buf_top_q;
    logic [CNT_W-1:0] act_a_q, act_b_q, act_top_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            buf_a_q   <= '0;
            buf_b_q   <= '0;
            buf_top_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_CMPA: buf_a_q   <= wr_data;
                ADDR_CMPB: buf_b_q   <= wr_data;
                ADDR_TOP:  buf_top_q <= wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_a_q   <= '0;
            act_b_q   <= '0;
            act_top_q <= '0;
        end else if (load_i) begin
            act_a_q   <= buf_a_q;
            act_b_q   <= buf_b_q;
            act_top_q <= buf_top_q;
        end
    end

    always_comb begin
        unique case (ctrl_q.top_src)
            SRC_FIX8:  top_o = CNT_W'((1 << 8) - 1);
            SRC_FIX9:  top_o = CNT_W'((1 << 9) - 1);
            SRC_FIX10: top_o = CNT_W'((1 << 10) - 1);
            SRC_CMPA:  top_o = act_a_q;
            default:   top_o = act_top_q;
        endcase
        ctrl_o  = ctrl_q;
        cmp_a_o = act_a_q;
        cmp_b_o = act_b_q;
    end

    // R10
    buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(act_a_q) && $stable(act_b_q) && $stable(act_top_q)))
        else $error("active compare or TOP changed without a load");

endmodule

// File: rtl/dslpwm_chan.sv
module dslpwm_chan
    import dslpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             falling_i,
    input  logic [1:0]       om_i,
    output logic             pin_o,
    output logic             oe_o
);

    logic lvl_q, lvl_d;

    always_comb begin
        if (cnt_i == top_i) begin
            lvl_d = lvl_q;
        end else if (cnt_i < cmp_i) begin
            lvl_d = 1'b1;
        end else begin
            lvl_d = falling_i && (cnt_i == cmp_i) && (cnt_i != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    always_comb begin
        oe_o = om_i[1];
        unique case (om_i)
            OM_PLAIN: pin_o = lvl_q;
            OM_INV:   pin_o = !lvl_q;
            default:  pin_o = 1'b0;
        endcase
    end

    // R7
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == top_i) |=> $stable(lvl_q))
        else $error("waveform changed on a match at TOP");

endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm
    import dslpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_a,
    output logic             oe_a,
    output logic             pwm_b,
    output logic             oe_b,
    output logic             top_flag
);

    localparam int CHANS = 2;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp_a, cmp_b, top_val, cnt;
    logic             run, tick, falling, load;
    logic [CNT_W-1:0] cmp_v [CHANS];
    logic [1:0]       om_v  [CHANS];
    logic             pin_v [CHANS];
    logic             oe_v  [CHANS];

    always_comb begin
        run      = run_en && sel_runs(ctrl.clk_sel);
        cmp_v[0] = cmp_a;
        cmp_v[1] = cmp_b;
        om_v[0]  = ctrl.om_a;
        om_v[1]  = ctrl.om_b;
        pwm_a    = pin_v[0];
        oe_a     = oe_v[0];
        pwm_b    = pin_v[1];
        oe_b     = oe_v[1];
    end

    dslpwm_shadow #(.CNT_W(CNT_W)) shadow_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load_i  (load),
        .ctrl_o  (ctrl),
        .cmp_a_o (cmp_a),
        .cmp_b_o (cmp_b),
        .top_o   (top_val)
    );

    dslpwm_prescale #(.PS_W(PS_W)) prescale_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .sel_i  (ctrl.clk_sel),
        .tick_o (tick)
    );

    dslpwm_ramp #(.CNT_W(CNT_W)) ramp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .tick_i     (tick),
        .freq_i     (ctrl.freq_mode),
        .top_i      (top_val),
        .cnt_o      (cnt),
        .falling_o  (falling),
        .load_o     (load),
        .top_flag_o (top_flag)
    );

    for (genvar g = 0; g < CHANS; g++) begin : g_chan
        dslpwm_chan #(.CNT_W(CNT_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_i     (cnt),
            .top_i     (top_val),
            .cmp_i     (cmp_v[g]),
            .falling_i (falling),
            .om_i      (om_v[g]),
            .pin_o     (pin_v[g]),
            .oe_o      (oe_v[g])
        );
    end

endmodule

// File: tb/dual_slope_pwm_tb_top.sv
module dual_slope_pwm_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, oe_a, pwm_b, oe_b, top_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dual_slope_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .oe_a(oe_a),
        .pwm_b(pwm_b), .oe_b(oe_b), .top_flag(top_flag)
    );

    // ctrl = {om_b[1:0], om_a[1:0], clk_sel[2:0], freq, top_src[2:0]}
    typedef struct packed {
        logic [10:0] ctrl;
        logic [15:0] top;
        logic [15:0] ca;
        logic [15:0] cb;
        logic [15:0] win;
        logic [15:0] exp_a;
        logic [15:0] exp_b;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{{2'b10, 2'b10, 3'd1, 1'b0, 3'd3}, 16'd20,  16'd5,   16'd12,  16'd40,   16'd10,   16'd24},
        '{{2'b10, 2'b11, 3'd1, 1'b1, 3'd3}, 16'd20,  16'd5,   16'd0,   16'd40,   16'd30,   16'd0},
        '{{2'b11, 2'b10, 3'd1, 1'b0, 3'd3}, 16'd20,  16'd20,  16'd20,  16'd40,   16'd40,   16'd0},
        '{{2'b10, 2'b10, 3'd1, 1'b0, 3'd4}, 16'd0,   16'd16,  16'd6,   16'd32,   16'd32,   16'd12},
        '{{2'b10, 2'b10, 3'd1, 1'b0, 3'd0}, 16'd0,   16'd100, 16'd300, 16'd510,  16'd200,  16'd510},
        '{{2'b00, 2'b10, 3'd2, 1'b0, 3'd3}, 16'd10,  16'd3,   16'd0,   16'd160,  16'd48,   16'd0},
        '{{2'b10, 2'b10, 3'd1, 1'b1, 3'd1}, 16'd0,   16'd0,   16'd1,   16'd1022, 16'd0,    16'd2},
        '{{2'b01, 2'b10, 3'd1, 1'b0, 3'd2}, 16'd0,   16'd512, 16'd0,   16'd2046, 16'd1024, 16'd0},
        '{{2'b10, 2'b10, 3'd1, 1'b0, 3'd5}, 16'd20,  16'd5,   16'd12,  16'd40,   16'd10,   16'd24},
        '{{2'b11, 2'b10, 3'd3, 1'b0, 3'd3}, 16'd10,  16'd5,   16'd2,   16'd1280, 16'd640,  16'd1024},
        '{{2'b10, 2'b11, 3'd4, 1'b1, 3'd3}, 16'd4,   16'd2,   16'd1,   16'd2048, 16'd1024, 16'd512},
        '{{2'b10, 2'b10, 3'd5, 1'b0, 3'd3}, 16'd4,   16'd1,   16'd3,   16'd8192, 16'd2048, 16'd6144}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        run_en = 1'b0;
        wr_en  = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [10:0] c, input logic [15:0] t,
                         input logic [15:0] a, input logic [15:0] b);
        do_reset();
        wr(2'd3, t);
        wr(2'd1, a);
        wr(2'd2, b);
        wr(2'd0, {5'd0, c});
    endtask

    // wait for a sample with top_flag high; returns 1 if seen
    task automatic wait_flag(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (top_flag) seen = 1'b1;
        end
    endtask

    task automatic count_win(input int w, output int na, output int nb,
                             output int nf);
        na = 0; nb = 0; nf = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            na += int'(pwm_a);
            nb += int'(pwm_b);
            nf += int'(top_flag);
        end
    endtask

    task automatic frozen_watch(input string req, input int cyc);
        int ta, tf;
        logic prev;
        ta = 0; tf = 0;
        prev = pwm_a;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (pwm_a != prev) ta++;
            prev = pwm_a;
            tf += int'(top_flag);
        end
        check({req, " pwm_a toggles"}, ta, 0);
        check({req, " top_flag pulses"}, tf, 0);
    endtask

    task automatic buffer_test(input bit freq, input int exp_first);
        bit seen;
        int na, nb, nf;
        setup({2'b10, 2'b10, 3'd1, freq, 3'd3}, 16'd20, 16'd5, 16'd5);
        run_en = 1'b1;
        wait_flag(200, seen);
        check("R10 flag seen", int'(seen), 1);
        // write compare B on the very clock the counter sits at TOP
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd15;
        count_win(40, na, nb, nf);
        check(freq ? "R10 freq-correct first window" : "R10 phase-correct first window",
              nb, exp_first);
        count_win(40, na, nb, nf);
        check("R10 second window", nb, 30);
    endtask

    initial begin
        bit seen;
        int na, nb, nf;

        // R12 reset state
        do_reset();
        check("R12 pwm_a", int'(pwm_a), 0);
        check("R12 pwm_b", int'(pwm_b), 0);
        check("R12 oe_a", int'(oe_a), 0);
        check("R12 oe_b", int'(oe_b), 0);
        check("R12 top_flag", int'(top_flag), 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R11 R13
        for (int v = 0; v < NV; v++) begin
            setup(VECS[v].ctrl, VECS[v].top, VECS[v].ca, VECS[v].cb);
            check($sformatf("R13 oe_a vec%0d", v), int'(oe_a), int'(VECS[v].ctrl[8]));
            check($sformatf("R4 oe_b vec%0d", v), int'(oe_b), int'(VECS[v].ctrl[10]));
            run_en = 1'b1;
            wait_flag(4 * int'(VECS[v].win) + 100, seen);
            check($sformatf("R1 flag seen vec%0d", v), int'(seen), 1);
            count_win(int'(VECS[v].win), na, nb, nf);
            check($sformatf("R2/R3/R6 pwm_a high count vec%0d", v), na, int'(VECS[v].exp_a));
            check($sformatf("R5/R7 pwm_b high count vec%0d", v), nb, int'(VECS[v].exp_b));
            check($sformatf("R11 flag pulses per period vec%0d", v), nf, 1);
        end

        // R8 stopped clock-select codes 0, 6, 7
        setup({2'b10, 2'b10, 3'd0, 1'b0, 3'd3}, 16'd20, 16'd5, 16'd12);
        run_en = 1'b1;
        frozen_watch("R8 cs=0", 300);
        wr(2'd0, {5'd0, 2'b10, 2'b10, 3'd6, 1'b0, 3'd3});
        frozen_watch("R8 cs=6", 300);
        wr(2'd0, {5'd0, 2'b10, 2'b10, 3'd7, 1'b0, 3'd3});
        frozen_watch("R8 cs=7", 300);

        // R9 run_en low freezes a running timer
        setup({2'b10, 2'b10, 3'd1, 1'b0, 3'd3}, 16'd20, 16'd5, 16'd12);
        run_en = 1'b1;
        repeat (33) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        frozen_watch("R9 run_en low", 200);
        run_en = 1'b1;
        wait_flag(200, seen);
        check("R9 resumes after run_en", int'(seen), 1);

        // R12 reset while running
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R12 mid-run pwm_a", int'(pwm_a), 0);
        check("R12 mid-run oe_a", int'(oe_a), 0);
        check("R12 mid-run oe_b", int'(oe_b), 0);
        check("R12 mid-run top_flag", int'(top_flag), 0);
        rst_n = 1'b1;

        // R10 buffered loads coinciding with the TOP turnaround
        buffer_test(1'b0, 10);
        buffer_test(1'b1, 20);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule